// File: doc/BRIEF.md
# Double-Buffered Serial Code Loader for a 12-Bit Converter

This block is the digital front end of a serial-input digital-to-analog converter. A word arrives one bit at a time on a serial data line, most significant bit first, while an active-low select is held low. Each bit enters an input shift register on a rising edge of the serial clock. A second register, the output code register, drives the converter. Shifting a new word in never touches that code. The analog output therefore holds its value until the host applies the active-low load strobe. While load is low, the output code follows the shift register.

An active-low clear forces the output code to zero at any moment, and it wins over load. The code is straight unipolar binary: 0x000 is zero output, 0x800 is mid-scale and 0xFFF is full scale. All five host pins are asynchronous to the block's system clock. They pass through a parameterised synchronizer and are then handled in the system clock domain. The serial clock is oversampled there and its rising edges are detected. The system clock must therefore run at more than twice the serial clock rate.

Top module: `dac_serial_front`

## Requirements
- R1: After a synchronous reset the output code is 0x000.
- R2: Shifting bits into the input register while load and clear are both high leaves the output code unchanged, both partway through a word and after a full word.
- R3: On each rising serial clock edge seen while select is low, the serial data bit enters the input register at bit 0 and earlier bits move one place toward bit 11. A 12-bit word sent most significant bit first therefore lands with its first bit in bit 11.
- R4: Serial clock edges that occur while select is high leave the input register unchanged. A later load then produces the word shifted in before those edges.
- R5: Load is level-sensitive. While load is low and clear is high, the output code equals the input register, including bits shifted in during that time.
- R6: Clear low forces the output code to 0x000 and leaves the input register untouched. A later load restores the word that was shifted in before the clear.
- R7: When clear and load are low together the output code is 0x000. Releasing clear while load stays low makes the output code equal the input register.
- R8: When more than 12 bits are clocked in during one select window, the input register keeps the last 12 bits received.
- R9: Codes carry through unchanged in straight binary: 0x000, 0x800, 0x7FF and 0xFFF each appear on the output exactly as shifted in.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the host pins |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk | input | 1 | Serial clock from the host, sampled on its rising edge |
| sdata | input | 1 | Serial data, most significant bit first |
| cs_n | input | 1 | Active-low select; serial clock edges count only while low |
| ld_n | input | 1 | Active-low level-sensitive load into the output code |
| clr_n | input | 1 | Active-low clear of the output code, priority over load |
| dac_code | output | DATA_W (12) | Code driving the converter, straight binary |

## Verification
The bench builds the block with DATA_W at 12 and SYNC_STAGES at 3. The extra synchronizer stage above the default lengthens the pin-to-register latency. This shows that the scoreboard's settling margins absorb the pipeline depth. It also shows that edge detection still works when the serial clock is held for only four system clocks per phase. The 12-bit width puts the mid-scale, one-below-mid-scale and all-ones codes within reach. It also lets a 16-bit burst test truncation to the final 12 bits.

// File: rtl/dac_sfe_pkg.sv
// Shared types for the serial DAC front end.
// Assumes: host pins are grouped so one synchronizer handles them all.
package dac_sfe_pkg;

    // Host pin bundle, kept together through the synchronizer.
    typedef struct packed {
        logic sclk;
        logic sdata;
        logic cs_n;
        logic ld_n;
        logic clr_n;
    } sfe_pins_t;

    localparam int PINS_W = $bits(sfe_pins_t);

    // Idle pin levels: clock low, select, load and clear deasserted.
    localparam sfe_pins_t PINS_IDLE = '{
        sclk:  1'b0,
        sdata: 1'b0,
        cs_n:  1'b1,
        ld_n:  1'b1,
        clr_n: 1'b1
    };

endpackage

// File: rtl/dac_sfe_sync.sv
// Multi-stage synchronizer for a bundle of asynchronous inputs.
// Assumes: each bit is an independent level; no bus coherence is needed.
// The reset value is per bit, so deasserted active-low pins reset high.
module dac_sfe_sync #(
    parameter int W      = 5,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0][W-1:0] stage_q;

    // Purpose: ripple the inputs through STAGES flops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
        end else begin
            stage_q[0] <= din;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign dout = stage_q[LAST];

endmodule

// File: rtl/dac_sfe_shifter.sv
// Input shift register with serial clock rising-edge detection.
// Assumes: inputs are already synchronous to clk, and clk runs at more
// than twice the serial clock rate. New bits enter at bit 0.
module dac_sfe_shifter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         sclk_s,
    input  logic         sdata_s,
    input  logic         cs_n_s,
    output logic         shift_en,
    output logic [W-1:0] shift_q
);

    logic sclk_prev;

    // Purpose: remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_prev <= 1'b0;
        else        sclk_prev <= sclk_s;
    end

    assign shift_en = sclk_s & ~sclk_prev & ~cs_n_s;

    // Purpose: shift one bit in on each qualified rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        shift_q <= '0;
        else if (shift_en) shift_q <= {shift_q[W-2:0], sdata_s};
    end

endmodule

// File: rtl/dac_sfe_holdreg.sv
// Output code register feeding the converter.
// Assumes: synchronous control levels. Clear has priority over load.
// While load is low the register tracks the shift register every cycle.
module dac_sfe_holdreg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ld_n_s,
    input  logic         clr_n_s,
    input  logic [W-1:0] shift_q,
    output logic [W-1:0] code_q
);

    // Purpose: clear, follow or hold the output code.
    always_ff @(posedge clk) begin
        if (!rst_n)        code_q <= '0;
        else if (!clr_n_s) code_q <= '0;
        else if (!ld_n_s)  code_q <= shift_q;
    end

endmodule

// File: rtl/dac_serial_front.sv
// Top of the double-buffered serial DAC front end.
// Synchronizes the host pins, shifts serial data in and drives the code.
// Assumes: clk is faster than twice the serial clock rate.
module dac_serial_front #(
    parameter int DATA_W      = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              sdata,
    input  logic              cs_n,
    input  logic              ld_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] dac_code
);
    import dac_sfe_pkg::*;

    sfe_pins_t         pins_raw;
    sfe_pins_t         pins_s;
    logic              sclk_s, sdata_s, cs_n_s, ld_n_s, clr_n_s;
    logic              shift_en;
    logic [DATA_W-1:0] shift_q;

    // Purpose: bundle the raw host pins.
    always_comb begin
        pins_raw.sclk  = sclk;
        pins_raw.sdata = sdata;
        pins_raw.cs_n  = cs_n;
        pins_raw.ld_n  = ld_n;
        pins_raw.clr_n = clr_n;
    end

    dac_sfe_sync #(
        .W       (PINS_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PINS_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pins_raw),
        .dout  (pins_s)
    );

    assign sclk_s  = pins_s.sclk;
    assign sdata_s = pins_s.sdata;
    assign cs_n_s  = pins_s.cs_n;
    assign ld_n_s  = pins_s.ld_n;
    assign clr_n_s = pins_s.clr_n;

    dac_sfe_shifter #(.W(DATA_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk_s   (sclk_s),
        .sdata_s  (sdata_s),
        .cs_n_s   (cs_n_s),
        .shift_en (shift_en),
        .shift_q  (shift_q)
    );

    dac_sfe_holdreg #(.W(DATA_W)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .ld_n_s  (ld_n_s),
        .clr_n_s (clr_n_s),
        .shift_q (shift_q),
        .code_q  (dac_code)
    );

endmodule

// File: rtl/dac_sfe_checker.sv
// Property checker for dac_serial_front, attached by bind below.
module dac_sfe_checker #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         sdata_s,
    input logic         cs_n_s,
    input logic         ld_n_s,
    input logic         clr_n_s,
    input logic         shift_en,
    input logic [W-1:0] shift_q,
    input logic [W-1:0] dac_code
);

    // R1: reset drives the output code to zero.
    p_reset_zero_r1: assert property (@(posedge clk)
        !rst_n |=> dac_code == '0);

    // R2: with load and clear idle the output code holds.
    p_hold_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_n_s && clr_n_s) |=> $stable(dac_code));

    // R3: a qualified edge puts the data bit at position 0.
    p_bit_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> shift_q[0] == $past(sdata_s));

    // R4: with select high the shift register stays put.
    p_cs_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n_s |=> $stable(shift_q));

    // R5: load low and clear high makes the code follow the shift register.
    p_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_n_s && clr_n_s) |=> dac_code == $past(shift_q));

    // R6, R7: clear low zeroes the code regardless of load.
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n_s |=> dac_code == '0);

endmodule

bind dac_serial_front dac_sfe_checker #(.W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sdata_s  (sdata_s),
    .cs_n_s   (cs_n_s),
    .ld_n_s   (ld_n_s),
    .clr_n_s  (clr_n_s),
    .shift_en (shift_en),
    .shift_q  (shift_q),
    .dac_code (dac_code)
);

// File: tb/dac_serial_front_test.sv
// Scoreboard bench: driver tasks queue expected codes, a monitor compares.
module dac_serial_front_test;

    localparam int W    = 12;
    localparam int HALF = 4;   // system clocks per serial clock phase

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sclk = 1'b0, sdata = 1'b0, cs_n = 1'b1, ld_n = 1'b1, clr_n = 1'b1;
    logic [W-1:0] dac_code;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [W-1:0] val;
        string        tag;
    } exp_t;
    exp_t exp_q[$];

    always #5 clk = ~clk;

    dac_serial_front #(.DATA_W(W), .SYNC_STAGES(3)) uut (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .sdata(sdata),
        .cs_n(cs_n), .ld_n(ld_n), .clr_n(clr_n), .dac_code(dac_code)
    );

    // Monitor: pop one expected item per falling edge and compare.
    always @(negedge clk) begin
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (dac_code !== e.val) begin
                errors++;
                $display("FAIL %s: dac_code=%03h expected=%03h", e.tag, dac_code, e.val);
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic expect_code(input logic [W-1:0] v, input string tag);
        exp_t e;
        e.val = v;
        e.tag = tag;
        exp_q.push_back(e);
        while (exp_q.size() > 0) @(posedge clk);
        #2;
    endtask

    // Clock n bits of v out MSB first; select level is left as is.
    task automatic clock_bits(input logic [31:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            sdata = v[i];
            sclk  = 1'b0;
            step(HALF);
            sclk  = 1'b1;
            step(HALF);
        end
        sclk = 1'b0;
        step(HALF + 2);
    endtask

    task automatic send_word(input logic [31:0] v, input int n);
        cs_n = 1'b0;
        step(2);
        clock_bits(v, n);
        cs_n = 1'b1;
        step(4);
    endtask

    task automatic pulse_load();
        ld_n = 1'b0;
        step(6);
        ld_n = 1'b1;
        step(6);
    endtask

    task automatic pulse_clear();
        clr_n = 1'b0;
        step(6);
        clr_n = 1'b1;
        step(6);
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(2);
        expect_code(12'h000, "R1 reset value");

        // R3: MSB-first word lands in order after load.
        send_word(32'hABC, 12);
        pulse_load();
        expect_code(12'hABC, "R3 MSB-first capture");

        // R2: partial and full shifting leave the output alone.
        cs_n = 1'b0;
        step(2);
        clock_bits(32'h12, 6);
        expect_code(12'hABC, "R2 output held mid-word");
        clock_bits(32'h23, 6);
        cs_n = 1'b1;
        step(4);
        expect_code(12'hABC, "R2 output held after word");
        pulse_load();
        expect_code(12'h4A3, "R3 second word capture");

        // R4: edges with select high are ignored.
        send_word(32'h5A5, 12);
        pulse_load();
        clock_bits(32'hFFF, 12);
        expect_code(12'h5A5, "R4 output after deselected edges");
        pulse_load();
        expect_code(12'h5A5, "R4 shift register kept through deselected edges");

        // R6: clear zeroes output but keeps the shift register.
        pulse_clear();
        expect_code(12'h000, "R6 output zero after clear");
        pulse_load();
        expect_code(12'h5A5, "R6 shift register survives clear");

        // R7: clear wins over load, then load takes over.
        send_word(32'h3C3, 12);
        ld_n  = 1'b0;
        clr_n = 1'b0;
        step(6);
        expect_code(12'h000, "R7 clear over load");
        clr_n = 1'b1;
        step(6);
        expect_code(12'h3C3, "R7 load after clear release");
        ld_n = 1'b1;
        step(6);

        // R5: load held low, output tracks the shifting.
        ld_n = 1'b0;
        step(6);
        cs_n = 1'b0;
        step(2);
        clock_bits(32'h0, 4);
        expect_code(12'hC30, "R5 follow after 4 bits");
        clock_bits(32'h0F, 8);
        expect_code(12'h00F, "R5 follow after full word");
        cs_n = 1'b1;
        ld_n = 1'b1;
        step(6);

        // R8: 16 bits in one window keep the final 12.
        send_word(32'hBEEF, 16);
        pulse_load();
        expect_code(12'hEEF, "R8 last 12 bits kept");

        // R9: code endpoints pass through unchanged.
        send_word(32'hFFF, 12);
        pulse_load();
        expect_code(12'hFFF, "R9 full scale");
        send_word(32'h800, 12);
        pulse_load();
        expect_code(12'h800, "R9 mid-scale");
        send_word(32'h7FF, 12);
        pulse_load();
        expect_code(12'h7FF, "R9 below mid-scale");
        send_word(32'h000, 12);
        pulse_load();
        expect_code(12'h000, "R9 zero scale");

        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: run incomplete, actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule